// File: doc/BRIEF.md
# Scan-Line Interrupt Controller

This block raises a programmable interrupt when the video raster reaches a chosen scan line. It sits next to the video timing logic of a display processor that already has a frame (vertical-blank) interrupt. It watches the current scan-line number, a blanking indication and an end-of-frame strobe. The host loads the controls through a byte-wide register write port: an enable bit, a target line and the frame-interrupt enable.

Both interrupt sources share one active-low output pin. The host tells them apart by reading two status registers. A read of status register 0 clears the frame flag. A read of status register 1 returns the line flag, the blanking state and a fixed chip identifier, and clears the line flag. If a new event arrives in the same cycle as the read that would clear its flag, the event is kept.

Top module: `slint_ctrl`

## Requirements
- R1: After reset the interrupt output is high, both flags are 0 and the target-line register is 0, so the line interrupt is off until the target is written.
- R2: When the line enable (register 0, mask 0x10) is set, the target (register 19) is non-zero and the scan-line input changes to a value equal to the target, the line flag is set at that clock edge and visible from the next cycle.
- R3: A target of zero never sets the line flag, whatever the enable and the scan line.
- R4: With the line enable clear the line flag is never set. All bits of register 0 other than mask 0x10 have no effect.
- R5: The line flag stays set until a status register 1 read. The read returns the flag as 1 and clears it at the end of that cycle.
- R6: The line flag is set at most once per line: after it is cleared, it stays 0 while the scan-line input holds the matching value.
- R7: If a clearing status read and a new set event for the same flag fall in one cycle, the flag ends up set.
- R8: The status register 1 byte is: bit 0 (LSB) the line flag, bit 1 the blanking input, bits 7:5 the CHIP_ID parameter (default 3'b011), bits 4:2 zero.
- R9: The end-of-frame strobe sets the frame flag whatever the frame enable. A status register 0 read clears it. The frame enable is register 1, mask 0x20.
- R10: The interrupt output is low exactly when (line flag and line enable) or (frame flag and frame enable) holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 6 | Register number being written |
| reg_wr_data | input | 8 | Register write data |
| scan_line | input | 8 | Current scan-line number from video timing |
| blank_in | input | 1 | 1 while the raster is in horizontal or vertical blanking |
| frame_end | input | 1 | One-cycle end-of-frame strobe |
| st0_rd | input | 1 | Host read of status register 0 (clears the frame flag) |
| st1_rd | input | 1 | Host read of status register 1 (clears the line flag) |
| st1_data | output | 8 | Status register 1 byte |
| frame_flag | output | 1 | Frame flag, for the status register 0 byte |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
The scan line is driven in three ways. Sequences that step through the target check that one edge sets the flag. Sequences that hold the matching line after a read check that the flag does not set again. Random jumps over a small range hit the target often and mix this with random register writes, including writes with a zero target and writes of stray register 0 bits. Status reads are placed in the cycle of a new match or frame strobe, which separates the rule that a set beats a clear from a plain clear. Changing the two enables while flags are pending shows whether the output pin follows the gated OR or the raw flags.

// File: rtl/slint_pkg.sv
// Shared constants for the scan-line interrupt controller: register
// numbers, enable masks and status register 1 bit positions.
package slint_pkg;
    localparam int REG_ADDR_W  = 6;
    localparam int DATA_W      = 8;
    localparam logic [REG_ADDR_W-1:0] ADDR_CTL0   = 6'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_CTL1   = 6'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_TARGET = 6'd19;
    localparam int LINE_EN_BIT  = 4;   // mask 0x10 in register 0
    localparam int FRAME_EN_BIT = 5;   // mask 0x20 in register 1
    localparam int ST1_HF_BIT   = 0;
    localparam int ST1_BLK_BIT  = 1;
    localparam int ID_W         = 3;
endpackage

// File: rtl/slint_ctl_regs.sv
// Control register file. It keeps only the fields this block uses: the
// line enable, the frame enable and the target line. Writes to any other
// register number, and other bits of registers 0 and 1, are dropped.
// Assumes one write strobe per cycle.
module slint_ctl_regs
    import slint_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  line_en,
    output logic                  frame_en,
    output logic [LINE_W-1:0]     target
);
    // Decode each write and update the matching field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_en  <= 1'b0;
            frame_en <= 1'b0;
            target   <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTL0)   line_en  <= wr_data[LINE_EN_BIT];
            if (wr_addr == ADDR_CTL1)   frame_en <= wr_data[FRAME_EN_BIT];
            if (wr_addr == ADDR_TARGET) target   <= wr_data[LINE_W-1:0];
        end
    end
endmodule

// File: rtl/slint_line_match.sv
// Detects the cycle in which the scan line changes to the target value.
// It gives one hit per line arrival, and none while the line holds.
// A zero target or a clear enable suppresses the hit. The first sample
// after reset is a baseline and never counts as a change.
module slint_line_match #(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] scan_line,
    input  logic [LINE_W-1:0] target,
    input  logic              line_en,
    output logic              hit
);
    logic [LINE_W-1:0] prev_line;
    logic              prev_vld;
    logic              line_chg;

    // Remember the last scan line seen, to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_line <= '0;
            prev_vld  <= 1'b0;
        end else begin
            prev_line <= scan_line;
            prev_vld  <= 1'b1;
        end
    end

    // Qualify a line change with the enable, a non-zero target and equality.
    always_comb begin
        line_chg = prev_vld && (scan_line != prev_line);
        hit      = line_en && (target != '0) && line_chg && (scan_line == target);
    end
endmodule

// File: rtl/slint_flag.sv
// Sticky event flag. A set pulse wins over a clear pulse in the same cycle,
// so an event arriving during a status read is not lost.
module slint_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag until a clear that is not overridden by a set.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/slint_ctrl.sv
// Top of the scan-line interrupt controller. It combines the control
// registers, the line matcher and two sticky flags (line and frame). It
// drives the shared active-low interrupt and the status register 1 byte.
// Assumes the read strobes are one cycle per host access.
module slint_ctrl
    import slint_pkg::*;
#(
    parameter int               LINE_W  = 8,
    parameter logic [ID_W-1:0]  CHIP_ID = 3'b011
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0]     reg_wr_data,
    input  logic [LINE_W-1:0]     scan_line,
    input  logic                  blank_in,
    input  logic                  frame_end,
    input  logic                  st0_rd,
    input  logic                  st1_rd,
    output logic [DATA_W-1:0]     st1_data,
    output logic                  frame_flag,
    output logic                  irq_n
);
    localparam int PAD_W = DATA_W - ID_W - 2;

    logic              line_en;
    logic              frame_en;
    logic [LINE_W-1:0] target;
    logic              line_hit;
    logic              line_flag;

    slint_ctl_regs #(.LINE_W(LINE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .line_en  (line_en),
        .frame_en (frame_en),
        .target   (target)
    );

    slint_line_match #(.LINE_W(LINE_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_line (scan_line),
        .target    (target),
        .line_en   (line_en),
        .hit       (line_hit)
    );

    slint_flag u_line_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (line_hit),
        .clr   (st1_rd),
        .q     (line_flag)
    );

    slint_flag u_frame_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (frame_end),
        .clr   (st0_rd),
        .q     (frame_flag)
    );

    // Assemble the status byte and the shared interrupt pin.
    always_comb begin
        st1_data = {CHIP_ID, {PAD_W{1'b0}}, blank_in, line_flag};
        irq_n    = !((line_flag && line_en) || (frame_flag && frame_en));
    end
endmodule

// File: rtl/slint_ctrl_chk.sv
// Assertion checker for slint_ctrl, attached by bind below.
module slint_ctrl_chk #(
    parameter int LINE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LINE_W-1:0] scan_line,
    input logic [LINE_W-1:0] target,
    input logic              line_en,
    input logic              line_flag,
    input logic              frame_flag,
    input logic              frame_end,
    input logic              st1_rd,
    input logic              irq_n
);
    a_r3_zero_target_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (target == '0) |=> !$rose(line_flag));
    a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |=> !$rose(line_flag));
    a_r2_rise_on_target: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_flag) |-> ($past(scan_line) == $past(target)));
    a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (line_flag && !st1_rd) |=> line_flag);
    a_r9_frame_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_flag) |-> $past(frame_end));
    a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_flag && !frame_flag) |-> irq_n);
endmodule

bind slint_ctrl slint_ctrl_chk #(.LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_line  (scan_line),
    .target     (target),
    .line_en    (line_en),
    .line_flag  (line_flag),
    .frame_flag (frame_flag),
    .frame_end  (frame_end),
    .st1_rd     (st1_rd),
    .irq_n      (irq_n)
);

// File: tb/tb_slint_ctrl.sv
module tb_slint_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [5:0] reg_wr_addr = '0;
    logic [7:0] reg_wr_data = '0;
    logic [7:0] scan_line = '0;
    logic       blank_in = 1'b0;
    logic       frame_end = 1'b0;
    logic       st0_rd = 1'b0;
    logic       st1_rd = 1'b0;
    logic [7:0] st1_data;
    logic       frame_flag;
    logic       irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state, built from the requirements.
    bit       m_hf, m_ff, m_hen, m_fen, m_pvld;
    bit [7:0] m_tgt, m_prev;

    slint_ctrl dut (.*);

    always #10 clk = ~clk;

    function automatic bit [7:0] exp_st1(bit hf, bit blk);
        return {3'b011, 3'b000, blk, hf};   // R8 layout
    endfunction

    function automatic bit exp_irq_n(bit hf, bit hen, bit ff, bit fen);
        return !((hf && hen) || (ff && fen)); // R10
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Check the outputs in mid-cycle, advance the model, then move to the next negedge.
    task automatic cyc(string tag);
        bit chg, hit;
        #2;
        chk(tag, "st1_data", st1_data, exp_st1(m_hf, blank_in));
        chk(tag, "irq_n", irq_n, exp_irq_n(m_hf, m_hen, m_ff, m_fen));
        chk(tag, "frame_flag", frame_flag, m_ff);
        chg = m_pvld && (scan_line != m_prev);
        hit = m_hen && (m_tgt != 0) && chg && (scan_line == m_tgt);
        m_hf = hit | (m_hf & ~st1_rd);
        m_ff = frame_end | (m_ff & ~st0_rd);
        m_prev = scan_line; m_pvld = 1;
        if (reg_wr_en) begin
            if (reg_wr_addr == 0)  m_hen = reg_wr_data[4];
            if (reg_wr_addr == 1)  m_fen = reg_wr_data[5];
            if (reg_wr_addr == 19) m_tgt = reg_wr_data;
        end
        @(negedge clk);
        reg_wr_en = 0; st0_rd = 0; st1_rd = 0; frame_end = 0;
    endtask

    task automatic wr(bit [5:0] a, bit [7:0] d, string tag);
        reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
        cyc(tag);
    endtask

    task automatic line(bit [7:0] l, string tag);
        scan_line = l;
        cyc(tag);
    endtask

    initial begin
        #3_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1", "irq_n", irq_n, 1);
        chk("R1", "hf", st1_data[0], 0);
        cyc("R1");
        // R2: arrive at target 5
        wr(0, 8'h10, "R2");
        wr(19, 8'd5, "R2");
        line(4, "R2"); line(5, "R2"); cyc("R2");
        chk("R2", "hf set", st1_data[0], 1);
        // R5: the read returns 1 and then clears
        st1_rd = 1; cyc("R5");
        // R6: holding the matching line does not set the flag again
        cyc("R6"); cyc("R6");
        chk("R6", "hf after hold", st1_data[0], 0);
        // R3: zero target
        wr(19, 8'd0, "R3");
        line(6, "R3"); line(0, "R3"); line(1, "R3");
        chk("R3", "hf zero tgt", st1_data[0], 0);
        // R4: other register 0 bits without the enable bit
        wr(19, 8'd3, "R4"); wr(0, 8'hEF, "R4");
        line(2, "R4"); line(3, "R4"); cyc("R4");
        chk("R4", "hf disabled", st1_data[0], 0);
        chk("R4", "irq disabled", irq_n, 1);
        wr(0, 8'h10, "R4"); line(4, "R4"); line(3, "R4"); cyc("R4");
        chk("R4", "hf enabled", st1_data[0], 1);
        // R7: a set in the cycle of the clearing read
        line(4, "R7"); st1_rd = 1; scan_line = 3; cyc("R7");
        chk("R7", "hf kept", st1_data[0], 1);
        // R10: line enable off masks the pin
        wr(0, 8'h00, "R10");
        chk("R10", "irq masked", irq_n, 1);
        // R9: frame flag and frame enable
        frame_end = 1; cyc("R9");
        chk("R9", "ff set", frame_flag, 1);
        chk("R9", "irq no fen", irq_n, 1);
        wr(1, 8'h20, "R9");
        chk("R10", "irq frame", irq_n, 0);
        frame_end = 1; st0_rd = 1; cyc("R7");
        chk("R7", "ff kept", frame_flag, 1);
        st0_rd = 1; cyc("R9");
        chk("R9", "ff cleared", frame_flag, 0);
        // R8: blanking bit
        blank_in = 1; #2 chk("R8", "st1 blank", st1_data, exp_st1(m_hf, 1));
        cyc("R8");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(2) == 0) scan_line = 8'($urandom_range(7));
            blank_in = $urandom_range(1);
            frame_end = ($urandom_range(15) == 0);
            st0_rd = ($urandom_range(3) == 0);
            st1_rd = ($urandom_range(3) == 0);
            if ($urandom_range(7) == 0) begin
                reg_wr_en = 1;
                case ($urandom_range(3))
                    0: reg_wr_addr = 0;
                    1: reg_wr_addr = 1;
                    2: reg_wr_addr = 19;
                    default: reg_wr_addr = 7;
                endcase
                reg_wr_data = (reg_wr_addr == 19) ? 8'($urandom_range(7))
                                                  : 8'($urandom_range(255));
            end
            cyc("R2/R3/R5/R7/R8/R9/R10");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule